// File: doc/BRIEF.md
# Three-Level In-Phase-Disposition PWM Modulator

This block turns three signed per-phase voltage reference words into gate signals for a three-phase inverter whose legs each clamp to a neutral point and can sit at one of three output levels: positive rail (P), neutral (O) or negative rail (N). A single signed common-mode word is added to every phase reference. Each sum is clipped to full scale and compared against two triangular carriers stacked one above the other and moving in step. The upper carrier covers zero to positive full scale and the lower carrier covers negative full scale to zero.

The comparison result picks the leg level. That level is then expanded into four switch gates. Each gate turns on only after a programmable dead time and turns off at once. A neutral step is forced between P and N. New references are sampled only at the carrier valley and peak, so each ramp uses one fixed value. A one-cycle strobe marks the start of every carrier period. All three phases share one carrier counter.

Top module: `npc_pwm_top`

## Requirements
- R1: The carrier count runs 0, 1, …, CARRIER_MAX, CARRIER_MAX-1, …, 1, 0, 1, … so one period lasts 2·CARRIER_MAX clocks. `period_start` is high for exactly the one clock in which the count is 0.
- R2: With v the latched phase value and c the carrier count, the level is P when v > c, N when v < c − CARRIER_MAX, and O otherwise. For a steady v, P lasts 2v−1 clocks per period when v > 0, N lasts 2|v|−1 clocks when v < 0, and O fills the remainder.
- R3: In each gate bus, bit 0 drives switch 1 (outer upper), bit 1 switch 2, bit 2 switch 3 and bit 3 switch 4 (outer lower). Level P requests switches 1 and 2, level O requests switches 2 and 3, and level N requests switches 3 and 4.
- R4: The signed common-mode word is added to each phase reference before the comparison.
- R5: The sum of reference and common-mode word is clipped to the range −CARRIER_MAX … +CARRIER_MAX.
- R6: Reference and common-mode inputs are sampled only on the clock edge at which the carrier count is 0 or CARRIER_MAX. Changes between those edges have no effect.
- R7: A gate goes high DEAD_CYC clocks after its switch starts being requested and goes low in the same clock the request ends. A request shorter than or equal to DEAD_CYC clocks produces no pulse.
- R8: A leg never moves directly between P and N. It spends exactly one clock at O in between.
- R9: Switches 1 and 3 are never on together, and neither are switches 2 and 4.
- R10: While `rst_n` is low, every gate output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_a | input | REF_W | Signed reference, phase A |
| ref_b | input | REF_W | Signed reference, phase B |
| ref_c | input | REF_W | Signed reference, phase C |
| cm_offset | input | REF_W | Signed common-mode word added to all phases |
| gate_a | output | 4 | Switch gates, phase A (bit 0 = switch 1) |
| gate_b | output | 4 | Switch gates, phase B |
| gate_c | output | 4 | Switch gates, phase C |
| period_start | output | 1 | One-clock strobe at the carrier valley |

## Verification
Each phase value is held steady, and the high clocks of all twelve gates are counted over a full period. The counts are compared with closed-form on-times derived from R2 and R7.

- A zero value separates the neutral mapping from the outer levels.
- Values at plus and minus full scale expose off-by-one errors at the carrier extremes.
- Small magnitudes produce pulses shorter than the dead time, which must vanish.
- Offset-bearing and out-of-range sums separate a correct addition from clipping.
- Seeded random references cover the general case.

Two directed sequences cover the timing rules:
- The inputs are changed and then restored within a single ramp. The period counts must stay unchanged.
- A full-scale reversal is applied just before the valley. The clock gaps between gate edges then show the forced neutral step and the exact dead time.

// File: rtl/npc_pwm_pkg.sv
package npc_pwm_pkg;

    typedef enum logic [1:0] {
        LVL_N = 2'd0,
        LVL_O = 2'd1,
        LVL_P = 2'd2
    } level_e;

    // Switch requests per level; bit 0 = switch 1 (outer upper) ... bit 3 = switch 4.
    function automatic logic [3:0] level_gates(level_e lvl);
        case (lvl)
            LVL_P:   return 4'b0011;
            LVL_O:   return 4'b0110;
            LVL_N:   return 4'b1100;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/npc_tri_carrier.sv
module npc_tri_carrier #(
    parameter int CARRIER_MAX = 1000,
    parameter int CW          = $clog2(CARRIER_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_o,
    output logic          extreme_o,
    output logic          valley_o
);
    localparam logic [CW-1:0] TOP = CW'(CARRIER_MAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          up;
    } car_st;

    car_st s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.cnt == TOP)
            s_d.up = 1'b0;
        else if (s_q.cnt == '0)
            s_d.up = 1'b1;
        s_d.cnt = s_d.up ? s_q.cnt + CW'(1) : s_q.cnt - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.up  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o     = s_q.cnt;
    assign valley_o  = (s_q.cnt == '0);
    assign extreme_o = (s_q.cnt == '0) || (s_q.cnt == TOP);

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= TOP);
    // R1
    peak_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == TOP) |=> (s_q.cnt == TOP - CW'(1)));
    // R1
    valley_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == '0) |=> (s_q.cnt == CW'(1)));

endmodule

// File: rtl/npc_leg.sv
module npc_leg
    import npc_pwm_pkg::*;
#(
    parameter int REF_W       = 12,
    parameter int CARRIER_MAX = 1000,
    parameter int DEAD_CYC    = 200,
    parameter int CW          = $clog2(CARRIER_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic signed [REF_W-1:0] ofs_i,
    input  logic [CW-1:0]           cnt_i,
    input  logic                    latch_i,
    output logic [3:0]              gate_o
);
    localparam int XW = REF_W + 1;
    localparam int DW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;
    localparam logic [DW-1:0]        DT_V   = DW'(DEAD_CYC);
    localparam logic signed [XW-1:0] CMAX_S = XW'(CARRIER_MAX);

    typedef struct packed {
        logic signed [REF_W-1:0] ref_v;
        level_e                  lvl;
        logic [3:0][DW-1:0]      on_cnt;
    } leg_st;

    leg_st s_d, s_q;

    logic signed [XW-1:0] sum, upper, lower, ref_x;
    level_e               tgt;
    logic [3:0]           want;

    always_comb begin
        s_d = s_q;
        // common-mode sum and clipping
        sum = $signed({ref_i[REF_W-1], ref_i}) + $signed({ofs_i[REF_W-1], ofs_i});
        if (latch_i) begin
            if (sum > CMAX_S)
                s_d.ref_v = CMAX_S[REF_W-1:0];
            else if (sum < -CMAX_S)
                s_d.ref_v = (-CMAX_S);
            else
                s_d.ref_v = sum[REF_W-1:0];
        end
        // stacked in-phase carriers
        upper = $signed(XW'(cnt_i));
        lower = upper - CMAX_S;
        ref_x = $signed({s_q.ref_v[REF_W-1], s_q.ref_v});
        if (ref_x > upper)
            tgt = LVL_P;
        else if (ref_x < lower)
            tgt = LVL_N;
        else
            tgt = LVL_O;
        // never jump between the outer levels
        if ((s_q.lvl == LVL_P && tgt == LVL_N) || (s_q.lvl == LVL_N && tgt == LVL_P))
            s_d.lvl = LVL_O;
        else
            s_d.lvl = tgt;
        // turn-on delay per switch
        want = level_gates(s_q.lvl);
        for (int i = 0; i < 4; i++) begin
            if (!want[i])
                s_d.on_cnt[i] = '0;
            else if (s_q.on_cnt[i] != DT_V)
                s_d.on_cnt[i] = s_q.on_cnt[i] + DW'(1);
            gate_o[i] = want[i] && (s_q.on_cnt[i] == DT_V);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ref_v  <= '0;
            s_q.lvl    <= LVL_O;
            s_q.on_cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R8
    p_to_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lvl == LVL_P) |=> (s_q.lvl != LVL_N));
    // R8
    n_to_p_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lvl == LVL_N) |=> (s_q.lvl != LVL_P));
    // R6
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_i |=> $stable(s_q.ref_v));
    // R9
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[0] && gate_o[2]) && !(gate_o[1] && gate_o[3]));

    for (genvar g = 0; g < 4; g++) begin : g_dead
        // R7
        dead_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((DEAD_CYC > 0) && $rose(gate_o[g])) |-> $past(want[g]));
    end

endmodule

// File: rtl/npc_pwm_top.sv
module npc_pwm_top #(
    parameter int REF_W       = 12,
    parameter int CARRIER_MAX = 1000,
    parameter int DEAD_CYC    = 200
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [REF_W-1:0] ref_a,
    input  logic signed [REF_W-1:0] ref_b,
    input  logic signed [REF_W-1:0] ref_c,
    input  logic signed [REF_W-1:0] cm_offset,
    output logic [3:0]              gate_a,
    output logic [3:0]              gate_b,
    output logic [3:0]              gate_c,
    output logic                    period_start
);
    localparam int PHASES = 3;
    localparam int CW     = $clog2(CARRIER_MAX + 1);

    logic [CW-1:0]           cnt;
    logic                    extreme;
    logic signed [REF_W-1:0] refs  [PHASES];
    logic [3:0]              gates [PHASES];

    assign refs[0] = ref_a;
    assign refs[1] = ref_b;
    assign refs[2] = ref_c;

    npc_tri_carrier #(
        .CARRIER_MAX (CARRIER_MAX),
        .CW          (CW)
    ) u_carrier (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_o     (cnt),
        .extreme_o (extreme),
        .valley_o  (period_start)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_leg
        npc_leg #(
            .REF_W       (REF_W),
            .CARRIER_MAX (CARRIER_MAX),
            .DEAD_CYC    (DEAD_CYC),
            .CW          (CW)
        ) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .ref_i   (refs[p]),
            .ofs_i   (cm_offset),
            .cnt_i   (cnt),
            .latch_i (extreme),
            .gate_o  (gates[p])
        );
    end

    assign gate_a = gates[0];
    assign gate_b = gates[1];
    assign gate_c = gates[2];

endmodule

// File: tb/npc_pwm_top_test.sv
`timescale 1ns/1ps
module npc_pwm_top_test;
    localparam int RW = 12;
    localparam int CM = 300;
    localparam int DT = 24;
    localparam int PER = 2 * CM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [RW-1:0] ref_a = '0, ref_b = '0, ref_c = '0, cm_offset = '0;
    logic [3:0] gate_a, gate_b, gate_c;
    logic period_start;

    int errors = 0;
    int checks = 0;
    int overlap = 0;

    always #2.5 clk = ~clk;

    npc_pwm_top #(.REF_W(RW), .CARRIER_MAX(CM), .DEAD_CYC(DT)) uut (
        .clk(clk), .rst_n(rst_n),
        .ref_a(ref_a), .ref_b(ref_b), .ref_c(ref_c), .cm_offset(cm_offset),
        .gate_a(gate_a), .gate_b(gate_b), .gate_c(gate_c),
        .period_start(period_start)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] gv(int p);
        return (p == 0) ? gate_a : (p == 1) ? gate_b : gate_c;
    endfunction

    task automatic tick();
        @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            if ((gv(p)[0] && gv(p)[2]) || (gv(p)[1] && gv(p)[3])) overlap++;
        end
    endtask

    task automatic wait_strobe();
        do tick(); while (!period_start);
    endtask

    function automatic int clip(int v);
        if (v > CM) return CM;
        if (v < -CM) return -CM;
        return v;
    endfunction

    // per-period on-clocks of switch sw for steady value v (R2, R3, R7)
    function automatic int exp_on(int v, int sw);
        int p_len, n_len;
        p_len = (v > 0) ? 2 * v - 1 : 0;
        n_len = (v < 0) ? -2 * v - 1 : 0;
        case (sw)
            0: return (p_len > DT) ? p_len - DT : 0;
            1: return (v < 0) ? ((PER - n_len > DT) ? PER - n_len - DT : 0) : PER;
            2: return (v > 0) ? ((PER - p_len > DT) ? PER - p_len - DT : 0) : PER;
            default: return (n_len > DT) ? n_len - DT : 0;
        endcase
    endfunction

    task automatic drive(int a, int b, int c, int o);
        ref_a = RW'(a); ref_b = RW'(b); ref_c = RW'(c); cm_offset = RW'(o);
    endtask

    task automatic run_case(string tag, int a, int b, int c, int o);
        int cnt [3][4];
        int v [3];
        drive(a, b, c, o);
        v[0] = clip(a + o); v[1] = clip(b + o); v[2] = clip(c + o);
        for (int p = 0; p < 3; p++) for (int s = 0; s < 4; s++) cnt[p][s] = 0;
        wait_strobe(); wait_strobe(); wait_strobe();
        for (int k = 0; k < PER; k++) begin
            for (int p = 0; p < 3; p++)
                for (int s = 0; s < 4; s++) cnt[p][s] += int'(gv(p)[s]);
            tick();
        end
        for (int p = 0; p < 3; p++)
            for (int s = 0; s < 4; s++)
                check($sformatf("%s phase%0d sw%0d v=%0d", tag, p, s + 1, v[p]),
                      cnt[p][s], exp_on(v[p], s));
    endtask

    initial begin
        int n, s1f, s2f, s3r, s4r;
        int c1, c3;
        logic [3:0] prev;
        void'($urandom(32'd20240611));
        // R10: gates low in reset
        repeat (4) tick();
        check("R10 gates in reset", int'({gate_a, gate_b, gate_c}), 0);
        rst_n = 1'b1;

        // R1: period length between strobes
        wait_strobe();
        n = 0;
        do begin tick(); n++; end while (!period_start);
        check("R1 period clocks", n, PER);
        tick();
        check("R1 strobe width", int'(period_start), 0);

        run_case("R3 neutral", 0, 0, 0, 0);
        run_case("R2 full scale", CM, -CM, 1, 0);
        run_case("R7 short pulses", 10, -10, -1, 0);
        run_case("R4 offset", 100, -50, 0, 40);
        run_case("R5 clip high", CM - 10, -CM + 10, 200, 100);
        run_case("R5 clip low", -CM + 5, 0, 50, -100);
        run_case("R5 word limits", 2047, -2048, 0, 0);

        // R6: change and restore within one ramp; period counts unchanged
        run_case("R6 baseline", 100, 0, 0, 0);
        wait_strobe();
        c1 = 0; c3 = 0;
        for (int k = 0; k < PER; k++) begin
            if (k == 5) drive(-200, 150, -150, 90);
            if (k == CM - 5) drive(100, 0, 0, 0);
            c1 += int'(gate_a[0]);
            c3 += int'(gate_a[2]);
            tick();
        end
        check("R6 sw1 unchanged", c1, exp_on(100, 0));
        check("R6 sw3 unchanged", c3, exp_on(100, 2));

        // R8 / R7: reversal just before the valley
        run_case("R8 setup", CM, 0, 0, 0);
        wait_strobe();
        repeat (PER - 3) tick();
        ref_a = RW'(-CM);
        s1f = -1; s2f = -1; s3r = -1; s4r = -1;
        prev = gate_a;
        for (int k = 0; k < 60; k++) begin
            tick();
            if (s1f < 0 && prev[0] && !gate_a[0]) s1f = k;
            if (s2f < 0 && prev[1] && !gate_a[1]) s2f = k;
            if (s3r < 0 && !prev[2] && gate_a[2]) s3r = k;
            if (s4r < 0 && !prev[3] && gate_a[3]) s4r = k;
            prev = gate_a;
        end
        check("R8 neutral step clocks", s2f - s1f, 1);
        check("R7 sw3 dead time", s3r - s1f, DT);
        check("R7 sw4 dead time", s4r - s2f, DT);

        // R2: seeded random references
        for (int r = 0; r < 10; r++) begin
            run_case("R2 random",
                     int'($urandom_range(0, 2 * (CM + 60))) - (CM + 60),
                     int'($urandom_range(0, 2 * (CM + 60))) - (CM + 60),
                     int'($urandom_range(0, 2 * (CM + 60))) - (CM + 60),
                     int'($urandom_range(0, 200)) - 100);
        end

        check("R9 pair overlap clocks", overlap, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(190000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule